// File: doc/BRIEF.md
# Trigger Event Labelling Sequencer

This block is the master sequencer that gives each accepted level-1 trigger a label. When an accept arrives while it is idle, it raises its own busy output, advances a 12-bit sequential event number, and builds a 16-bit event word. The low twelve bits of that word carry the number and the high four bits carry a type code. The word is placed on the data port, and a one-cycle strobe marks it valid. The sequencer then holds its busy output high until every enabled readout controller has acknowledged the event. A readout acknowledges by raising its busy line and then letting it fall.

The type code is taken directly from a 4-bit special-event input pattern, so ordinary triggers arrive as 0000. A separate synchronisation request starts a burst of sync events, each with type 1111. The burst repeats the whole transfer-and-handshake cycle a programmable number of times, so that events waiting in a pipelined readout buffer are pushed out. A small write-only register port sets the readout enables, the sync repeat count and the handshake timeout. Triggers that arrive while the block is busy are dropped and tallied.

Top module: `event_tagger`

## Requirements
- R1: After reset, gen_busy, evt_strobe, sync_active and timeout_err are low, evt_word and lost_count are zero, and the event counter is zero, so the first issued event carries number 1. The reset configuration enables every readout, sets the sync repeat count to FLUSH_DEF (4) and sets the timeout to TMO_DEF.
- R2: evt_word[11:0] holds the event number and evt_word[15:12] holds the type. Each issued event, whether normal or sync, carries the previous number plus one, and the number wraps from 4095 to 0.
- R3: When l1_accept is high at a clock edge while gen_busy is low and sync_req is low, gen_busy is high after that edge and evt_word has been loaded in the same edge. Its type field is the special_type pattern sampled at that edge (0000 for a normal trigger; 1000, 0100, 0010 and 0001 are the special codes).
- R4: evt_strobe is high for exactly one cycle, in the cycle after evt_word is loaded, and evt_word does not change at the edge that raises evt_strobe.
- R5: gen_busy stays high until every enabled readout has been seen with ro_busy high (after the strobe) and all enabled ro_busy lines are low. It falls at the first clock edge where both hold.
- R6: A readout whose enable bit is 0 is treated as never busy and as already acknowledged. Its ro_busy level has no effect, and with all readouts disabled, gen_busy falls at the edge after the strobe.
- R7: An l1_accept seen while gen_busy is high, or in the same edge as an accepted sync_req, issues no event and leaves the number sequence unchanged. It increments lost_count by one per cycle, and lost_count saturates at 2^LOST_W-1.
- R8: A sync_req seen while idle issues a burst of sync events with type 1111, each with its own strobe and handshake. The burst holds gen_busy high throughout and has as many events as the repeat count; a count of 0 issues one event. sync_active is high for the whole burst.
- R9: If a handshake is not complete within the timeout limit (the number of clock cycles spent waiting), timeout_err is set and stays set until reset. gen_busy and sync_active fall, and any remaining sync events are cancelled.
- R10: A write with cfg_we high selects a register by cfg_addr. Address 0 sets the readout enables from cfg_wdata[N_RO-1:0] (bit i enables ro_busy[i]), address 1 sets the sync repeat count from cfg_wdata[FLUSH_W-1:0], and address 2 sets the timeout limit. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_accept | input | 1 | Level-1 accept request |
| special_type | input | 4 | Special-event pattern copied into the type field |
| sync_req | input | 1 | Starts a burst of sync events |
| ro_busy | input | N_RO | Busy lines of the readout controllers |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | TMO_W | Configuration write data |
| gen_busy | output | 1 | Sequencer busy |
| evt_word | output | 16 | Event word: type in 15:12, number in 11:0 |
| evt_strobe | output | 1 | One-cycle valid strobe for evt_word |
| sync_active | output | 1 | High during a sync burst |
| lost_count | output | LOST_W | Saturating count of dropped accepts |
| timeout_err | output | 1 | Sticky handshake timeout flag |

## Verification
The bench builds the block with three readouts, LOST_W of 3 and TMO_W of 8, and keeps the default 12-bit event number. With these values the lost-trigger counter saturates after seven dropped accepts, and a timeout of ten cycles can be programmed and reached quickly. The full 4096-event wrap is exercised with every readout disabled, so each event takes only a few cycles. A staggered handshake, in which readouts rise and fall one at a time, shows that a line which has fallen does not count as acknowledged until every enabled readout has responded.

// File: rtl/evtag_pkg.sv
package evtag_pkg;
  localparam int NUM_W  = 12;
  localparam int TYPE_W = 4;
  localparam int WORD_W = NUM_W + TYPE_W;

  localparam logic [TYPE_W-1:0] TYPE_SYNC = 4'b1111;

  localparam logic [1:0] CFG_ENABLES = 2'd0;
  localparam logic [1:0] CFG_FLUSH   = 2'd1;
  localparam logic [1:0] CFG_TIMEOUT = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_WAIT    = 2'd2
  } seq_state_t;
endpackage

// File: rtl/evtag_cfg.sv
module evtag_cfg
  import evtag_pkg::*;
#(
  parameter int N_RO      = 3,
  parameter int FLUSH_W   = 4,
  parameter int FLUSH_DEF = 4,
  parameter int TMO_W     = 16,
  parameter int TMO_DEF   = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [TMO_W-1:0]   wdata,
  output logic [N_RO-1:0]    ro_en,
  output logic [FLUSH_W-1:0] flush_cnt,
  output logic [TMO_W-1:0]   tmo_limit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ro_en     <= '1;
      flush_cnt <= FLUSH_W'(FLUSH_DEF);
      tmo_limit <= TMO_W'(TMO_DEF);
    end else if (we) begin
      case (addr)
        CFG_ENABLES: ro_en     <= wdata[N_RO-1:0];
        CFG_FLUSH:   flush_cnt <= wdata[FLUSH_W-1:0];
        CFG_TIMEOUT: tmo_limit <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evtag_resp_track.sv
module evtag_resp_track #(
  parameter int N_RO = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            track,
  input  logic [N_RO-1:0] busy,
  input  logic [N_RO-1:0] en,
  output logic            all_done
);
  logic [N_RO-1:0] seen_q;
  logic [N_RO-1:0] ok;

  for (genvar i = 0; i < N_RO; i++) begin : g_ro
    always_ff @(posedge clk) begin
      if (rst || clear) seen_q[i] <= 1'b0;
      else if (track && en[i] && busy[i]) seen_q[i] <= 1'b1;
    end
    // a disabled readout counts as acknowledged and idle
    assign ok[i] = ~en[i] | (seen_q[i] & ~busy[i]);
  end

  assign all_done = &ok;
endmodule

// File: rtl/evtag_lost_ctr.sv
module evtag_lost_ctr #(
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [LOST_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && (count != {LOST_W{1'b1}})) count <= count + LOST_W'(1);
  end
endmodule

// File: rtl/evtag_seq.sv
module evtag_seq
  import evtag_pkg::*;
#(
  parameter int FLUSH_W = 4,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               l1_accept,
  input  logic [TYPE_W-1:0]  special_type,
  input  logic               sync_req,
  input  logic               resp_done,
  input  logic [FLUSH_W-1:0] flush_cnt,
  input  logic [TMO_W-1:0]   tmo_limit,
  output logic               track_clear,
  output logic               track_en,
  output logic               lost_evt,
  output logic               gen_busy,
  output logic [WORD_W-1:0]  evt_word,
  output logic               evt_strobe,
  output logic               sync_active,
  output logic               timeout_err
);
  seq_state_t         st_q;
  logic [NUM_W-1:0]   num_q;
  logic [NUM_W-1:0]   num_nx;
  logic [FLUSH_W-1:0] rem_q;
  logic [FLUSH_W-1:0] rem_init;
  logic [TMO_W-1:0]   tmo_q;
  logic [TMO_W-1:0]   tmo_last;
  logic               more_sync;

  assign num_nx    = num_q + NUM_W'(1);
  assign rem_init  = (flush_cnt == '0) ? FLUSH_W'(1) : flush_cnt;
  assign tmo_last  = tmo_limit - TMO_W'(1);
  assign more_sync = sync_active && (rem_q > FLUSH_W'(1));

  assign track_clear = (st_q == ST_PRESENT);
  assign track_en    = (st_q == ST_WAIT);
  assign lost_evt    = l1_accept && ((st_q != ST_IDLE) || sync_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      num_q       <= '0;
      rem_q       <= '0;
      tmo_q       <= '0;
      gen_busy    <= 1'b0;
      evt_word    <= '0;
      evt_strobe  <= 1'b0;
      sync_active <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      evt_strobe <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (sync_req) begin
            num_q       <= num_nx;
            evt_word    <= {TYPE_SYNC, num_nx};
            rem_q       <= rem_init;
            sync_active <= 1'b1;
            gen_busy    <= 1'b1;
            st_q        <= ST_PRESENT;
          end else if (l1_accept) begin
            num_q    <= num_nx;
            evt_word <= {special_type, num_nx};
            gen_busy <= 1'b1;
            st_q     <= ST_PRESENT;
          end
        end
        ST_PRESENT: begin
          evt_strobe <= 1'b1;
          tmo_q      <= '0;
          st_q       <= ST_WAIT;
        end
        ST_WAIT: begin
          if (resp_done) begin
            if (more_sync) begin
              rem_q    <= rem_q - FLUSH_W'(1);
              num_q    <= num_nx;
              evt_word <= {TYPE_SYNC, num_nx};
              st_q     <= ST_PRESENT;
            end else begin
              gen_busy    <= 1'b0;
              sync_active <= 1'b0;
              rem_q       <= '0;
              st_q        <= ST_IDLE;
            end
          end else if (tmo_q == tmo_last) begin
            timeout_err <= 1'b1;
            gen_busy    <= 1'b0;
            sync_active <= 1'b0;
            rem_q       <= '0;
            st_q        <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + TMO_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/event_tagger.sv
module event_tagger
  import evtag_pkg::*;
#(
  parameter int N_RO      = 3,
  parameter int LOST_W    = 8,
  parameter int FLUSH_W   = 4,
  parameter int FLUSH_DEF = 4,
  parameter int TMO_W     = 16,
  parameter int TMO_DEF   = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l1_accept,
  input  logic [3:0]        special_type,
  input  logic              sync_req,
  input  logic [N_RO-1:0]   ro_busy,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [TMO_W-1:0]  cfg_wdata,
  output logic              gen_busy,
  output logic [15:0]       evt_word,
  output logic              evt_strobe,
  output logic              sync_active,
  output logic [LOST_W-1:0] lost_count,
  output logic              timeout_err
);
  logic [N_RO-1:0]    ro_en;
  logic [FLUSH_W-1:0] flush_cnt;
  logic [TMO_W-1:0]   tmo_limit;
  logic               track_clear;
  logic               track_en;
  logic               resp_done;
  logic               lost_evt;

  evtag_cfg #(
    .N_RO(N_RO), .FLUSH_W(FLUSH_W), .FLUSH_DEF(FLUSH_DEF),
    .TMO_W(TMO_W), .TMO_DEF(TMO_DEF)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ro_en(ro_en), .flush_cnt(flush_cnt), .tmo_limit(tmo_limit)
  );

  evtag_resp_track #(.N_RO(N_RO)) u_track (
    .clk(clk), .rst(rst), .clear(track_clear), .track(track_en),
    .busy(ro_busy), .en(ro_en), .all_done(resp_done)
  );

  evtag_lost_ctr #(.LOST_W(LOST_W)) u_lost (
    .clk(clk), .rst(rst), .inc(lost_evt), .count(lost_count)
  );

  evtag_seq #(.FLUSH_W(FLUSH_W), .TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst(rst), .l1_accept(l1_accept), .special_type(special_type),
    .sync_req(sync_req), .resp_done(resp_done), .flush_cnt(flush_cnt),
    .tmo_limit(tmo_limit), .track_clear(track_clear), .track_en(track_en),
    .lost_evt(lost_evt), .gen_busy(gen_busy), .evt_word(evt_word),
    .evt_strobe(evt_strobe), .sync_active(sync_active),
    .timeout_err(timeout_err)
  );
endmodule

// File: rtl/event_tagger_chk.sv
module event_tagger_chk #(
  parameter int LOST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              l1_accept,
  input logic              sync_req,
  input logic              gen_busy,
  input logic [15:0]       evt_word,
  input logic              evt_strobe,
  input logic              sync_active,
  input logic [LOST_W-1:0] lost_count,
  input logic              timeout_err
);
  logic [11:0] last_num;
  logic        have_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_num  <= '0;
      have_last <= 1'b0;
    end else if (evt_strobe) begin
      last_num  <= evt_word[11:0];
      have_last <= 1'b1;
    end
  end

  a_r1_first_number: assert property (@(posedge clk) disable iff (rst)
    (evt_strobe && !have_last) |-> (evt_word[11:0] == 12'd1));

  a_r2_number_step: assert property (@(posedge clk) disable iff (rst)
    (evt_strobe && have_last) |-> (evt_word[11:0] == last_num + 12'd1));

  a_r3_accept_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (l1_accept && !gen_busy) |=> gen_busy);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    evt_strobe |=> !evt_strobe);

  a_r4_word_settled: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_strobe) |-> ($stable(evt_word) && gen_busy));

  a_r7_lost_step: assert property (@(posedge clk) disable iff (rst)
    (l1_accept && gen_busy && (lost_count != {LOST_W{1'b1}}))
      |=> (lost_count == $past(lost_count) + LOST_W'(1)));

  a_r7_lost_saturate: assert property (@(posedge clk) disable iff (rst)
    (lost_count == {LOST_W{1'b1}}) |=> (lost_count == {LOST_W{1'b1}}));

  a_r8_sync_type: assert property (@(posedge clk) disable iff (rst)
    (evt_strobe && sync_active) |-> (evt_word[15:12] == 4'b1111));

  a_r8_sync_under_busy: assert property (@(posedge clk) disable iff (rst)
    sync_active |-> gen_busy);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);

  a_r8_idle_sync_start: assert property (@(posedge clk) disable iff (rst)
    (sync_req && !gen_busy) |=> sync_active);
endmodule

bind event_tagger event_tagger_chk #(.LOST_W(LOST_W)) u_chk (
  .clk(clk), .rst(rst), .l1_accept(l1_accept), .sync_req(sync_req),
  .gen_busy(gen_busy), .evt_word(evt_word), .evt_strobe(evt_strobe),
  .sync_active(sync_active), .lost_count(lost_count),
  .timeout_err(timeout_err)
);

// File: tb/tb_event_tagger.sv
module tb_event_tagger;
  localparam int CLK_PERIOD = 10;
  localparam int N_RO   = 3;
  localparam int LOST_W = 3;
  localparam int TMO_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              l1_accept = 1'b0;
  logic [3:0]        special_type = '0;
  logic              sync_req = 1'b0;
  logic [N_RO-1:0]   ro_busy = '0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [TMO_W-1:0]  cfg_wdata = '0;
  logic              gen_busy;
  logic [15:0]       evt_word;
  logic              evt_strobe;
  logic              sync_active;
  logic [LOST_W-1:0] lost_count;
  logic              timeout_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [11:0] exp_num = '0;

  event_tagger #(
    .N_RO(N_RO), .LOST_W(LOST_W), .FLUSH_W(4), .FLUSH_DEF(4),
    .TMO_W(TMO_W), .TMO_DEF(200)
  ) dut (
    .clk(clk), .rst(rst), .l1_accept(l1_accept), .special_type(special_type),
    .sync_req(sync_req), .ro_busy(ro_busy), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gen_busy(gen_busy),
    .evt_word(evt_word), .evt_strobe(evt_strobe), .sync_active(sync_active),
    .lost_count(lost_count), .timeout_err(timeout_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = TMO_W'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic wait_strobe(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (evt_strobe) begin got = 1'b1; break; end
    end
  endtask

  // normal event with all enabled readouts pulsing busy together
  task automatic t_event(input logic [3:0] pat, input logic [N_RO-1:0] mask, input string req);
    exp_num = exp_num + 12'd1;
    l1_accept = 1'b1; special_type = pat;
    tick();
    l1_accept = 1'b0;
    chk("R3", {req, " busy after accept"}, int'(gen_busy), 1);
    chk("R3", {req, " word loaded"}, int'(evt_word), int'({pat, exp_num}));
    chk("R4", {req, " no strobe yet"}, int'(evt_strobe), 0);
    tick();
    chk("R4", {req, " strobe"}, int'(evt_strobe), 1);
    chk("R2", {req, " word at strobe"}, int'(evt_word), int'({pat, exp_num}));
    ro_busy = mask;
    tick();
    chk("R4", {req, " strobe one wide"}, int'(evt_strobe), 0);
    chk("R5", {req, " busy while ro busy"}, int'(gen_busy), 1);
    ro_busy = '0;
    tick();
    chk("R5", {req, " released"}, int'(gen_busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "gen_busy", int'(gen_busy), 0);
    chk("R1", "strobe", int'(evt_strobe), 0);
    chk("R1", "word", int'(evt_word), 0);
    chk("R1", "lost", int'(lost_count), 0);
    chk("R1", "err", int'(timeout_err), 0);
    chk("R1", "sync_active", int'(sync_active), 0);
  endtask

  task automatic t_normals();
    t_event(4'b0000, 3'b111, "R3 normal");
    t_event(4'b1000, 3'b111, "R3 tof ped");
    t_event(4'b0100, 3'b111, "R3 si ped");
    t_event(4'b0010, 3'b111, "R3 si cal");
    t_event(4'b0001, 3'b111, "R3 reserved");
  endtask

  task automatic t_stagger();
    bit got;
    exp_num = exp_num + 12'd1;
    l1_accept = 1'b1; special_type = 4'b0000;
    tick(); l1_accept = 1'b0;
    wait_strobe(got);
    chk("R5", "stagger strobe", int'(got), 1);
    ro_busy = 3'b001; tick();
    ro_busy = 3'b000; tick();
    chk("R5", "held, ro1/ro2 not seen", int'(gen_busy), 1);
    ro_busy = 3'b010; tick();
    chk("R5", "held, ro1 busy", int'(gen_busy), 1);
    ro_busy = 3'b000; tick();
    chk("R5", "held, ro2 not seen", int'(gen_busy), 1);
    ro_busy = 3'b100; tick();
    chk("R5", "held, ro2 busy", int'(gen_busy), 1);
    ro_busy = 3'b000; tick();
    chk("R5", "released after all", int'(gen_busy), 0);
  endtask

  task automatic t_lost();
    bit got;
    exp_num = exp_num + 12'd1;
    l1_accept = 1'b1; special_type = 4'b0000;
    tick(); l1_accept = 1'b0;
    tick();
    chk("R7", "strobe", int'(evt_strobe), 1);
    l1_accept = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      tick();
      if (k == 3) chk("R7", "lost after 3", int'(lost_count), 3);
      if (k > 0) chk("R7", "no strobe while busy", int'(evt_strobe), 0);
    end
    l1_accept = 1'b0;
    chk("R7", "lost saturates", int'(lost_count), 7);
    chk("R7", "word unchanged", int'(evt_word[11:0]), int'(exp_num));
    ro_busy = 3'b111; tick();
    ro_busy = 3'b000; tick();
    chk("R7", "released", int'(gen_busy), 0);
    exp_num = exp_num + 12'd1;
    l1_accept = 1'b1; tick(); l1_accept = 1'b0;
    wait_strobe(got);
    chk("R7", "next number not skipped", int'(evt_word[11:0]), int'(exp_num));
    ro_busy = 3'b111; tick(); ro_busy = 3'b000; tick();
  endtask

  task automatic t_disable();
    bit got;
    cfg_write(2'd0, 1);
    ro_busy = 3'b110;
    exp_num = exp_num + 12'd1;
    l1_accept = 1'b1; tick(); l1_accept = 1'b0;
    wait_strobe(got);
    ro_busy = 3'b111; tick();
    ro_busy = 3'b110; tick();
    chk("R6", "disabled busy ignored", int'(gen_busy), 0);
    ro_busy = 3'b000;
    cfg_write(2'd0, 0);
    cfg_write(2'd3, 255);
    exp_num = exp_num + 12'd1;
    l1_accept = 1'b1; tick(); l1_accept = 1'b0;
    tick();
    chk("R6", "strobe all disabled", int'(evt_strobe), 1);
    tick();
    chk("R10", "addr 3 ignored, no readout needed", int'(gen_busy), 0);
  endtask

  task automatic t_wrap();
    bit seen_top = 1'b0;
    while (1) begin
      exp_num = exp_num + 12'd1;
      l1_accept = 1'b1; tick(); l1_accept = 1'b0;
      tick(); tick();
      if (exp_num == 12'd4095) begin
        chk("R2", "number 4095", int'(evt_word[11:0]), 4095);
        seen_top = 1'b1;
      end else if (seen_top) begin
        chk("R2", "wrap to 0", int'(evt_word[11:0]), 0);
        break;
      end
    end
    cfg_write(2'd0, 7);
  endtask

  task automatic t_sync(input int n, input string what);
    bit got;
    int strobes = 0;
    sync_req = 1'b1; l1_accept = 1'b0; tick(); sync_req = 1'b0;
    chk("R8", {what, " active"}, int'(sync_active), 1);
    for (int k = 0; k < n; k++) begin
      wait_strobe(got);
      if (got) begin
        strobes++;
        exp_num = exp_num + 12'd1;
        chk("R8", {what, " sync word"}, int'(evt_word), int'({4'b1111, exp_num}));
        chk("R8", {what, " busy in burst"}, int'(gen_busy), 1);
      end
      ro_busy = 3'b111; tick(); ro_busy = 3'b000;
    end
    tick();
    chk("R8", {what, " released"}, int'(gen_busy), 0);
    chk("R8", {what, " inactive"}, int'(sync_active), 0);
    for (int k = 0; k < 10; k++) begin
      tick();
      if (evt_strobe) strobes++;
    end
    chk("R8", {what, " event count"}, strobes, n);
  endtask

  task automatic t_timeout();
    bit got;
    int strobes = 0;
    cfg_write(2'd2, 10);
    cfg_write(2'd1, 4);
    cfg_write(2'd0, 1);
    chk("R9", "err clear before", int'(timeout_err), 0);
    sync_req = 1'b1; tick(); sync_req = 1'b0;
    wait_strobe(got);
    exp_num = exp_num + 12'd1;
    ro_busy = 3'b001;
    for (int k = 0; k < 30; k++) begin
      tick();
      if (evt_strobe) strobes++;
    end
    chk("R9", "err set", int'(timeout_err), 1);
    chk("R9", "busy released", int'(gen_busy), 0);
    chk("R9", "sync cancelled", int'(sync_active), 0);
    chk("R9", "no further sync events", strobes, 0);
    ro_busy = 3'b000;
    t_event(4'b0000, 3'b001, "R9 after timeout");
    chk("R9", "err sticky", int'(timeout_err), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_normals();
    t_stagger();
    t_lost();
    t_disable();
    t_wrap();
    t_sync(4, "R8 default");
    cfg_write(2'd1, 2);
    t_sync(2, "R8 two");
    cfg_write(2'd1, 0);
    t_sync(1, "R8 zero");
    t_timeout();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule